// File: doc/BRIEF.md
# Double-Buffered SPI Transfer Controller

This block moves bytes over a four-wire serial link as either the clock-driving master or a selected slave. Software-facing logic writes a byte into a one-byte holding buffer. The controller copies that byte into a separate shift register as soon as the shift register is free, so the next byte can be written while the current one is still going out. A buffer-empty flag, with an optional interrupt request, tells the writer when the holding buffer can take another byte. A busy flag reports shift-register activity in master mode and the slave-select state in slave mode.

In master mode an external baud tick paces the serial clock. Each tick produces one SCLK edge, so one byte takes sixteen ticks. In slave mode the serial clock and the active-low slave-select come from the far side and pass through synchronizers. In both modes the idle clock level is chosen by a polarity bit and the sampling edge by a phase bit. Each received byte is presented together with a one-cycle completion strobe. Configuration inputs are expected to change only while the enable input is low.

Top module: `spi_xfer_ctrl`

## Requirements
- R1: After reset the buffer-empty flag is 1, busy is 0, SDO is 0, sclk_oe is 0 and the interrupt request is 0.
- R2: While cfg_en is 0, no byte leaves the holding buffer, baud ticks produce no SCLK edges, sclk_oe is 0, sclk_out sits at cfg_cpol and master busy reads 0.
- R3: A txd_wr pulse clears the buffer-empty flag in the next cycle. The flag returns to 1 when the byte moves into the shift register. If a write and that hand-off happen in the same cycle, the old byte is shifted and the new byte stays buffered, so the flag reads 0.
- R4: A write while the buffer-empty flag is 0 replaces the waiting byte. The replaced byte is never transmitted and no error indication appears.
- R5: Bytes leave on SDO most-significant bit first. With cfg_cpha=0, SDO is valid before the leading edge (the edge leaving the cfg_cpol level) and changes on the trailing edge. With cfg_cpha=1, SDO changes on the leading edge and is sampled on the trailing edge. SDI is captured on the same sampling edge as SDO is sampled.
- R6: In master mode with a byte in flight, each baud_tick toggles sclk_out once, and sclk_out holds between ticks. A byte takes 16 ticks, and afterwards sclk_out rests at cfg_cpol.
- R7: In master mode, busy becomes 1 in the cycle the shift register is loaded. It returns to 0 with the 16th SCLK edge of the last byte.
- R8: If the holding buffer is full when a byte finishes, the next byte is loaded in that same cycle. There is no idle SCLK gap, and master busy stays 1 across the boundary.
- R9: In slave mode, busy equals the synchronized inverse of ss_n_in. The synchronizer is two flip-flop stages at the default setting.
- R10: In slave mode, a byte is loaded and shifted only while the slave is selected. SCLK edges while deselected are ignored. Deselecting in mid-byte abandons that byte and restarts the bit count, and a byte waiting in the holding buffer is kept for the next selection.
- R11: irq is 1 exactly when the buffer-empty flag is 1 and cfg_irq_en is 1.
- R12: xfer_done pulses for one cycle when the eighth bit has been sampled. At that point rx_byte holds the received byte, first-received bit in bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Enables transfers and the serial clock |
| cfg_master | input | 1 | 1 selects master mode, 0 selects slave mode |
| cfg_cpol | input | 1 | Idle level of SCLK |
| cfg_cpha | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| cfg_irq_en | input | 1 | Enables the buffer-empty interrupt request |
| txd_wr | input | 1 | Write strobe for the holding buffer |
| txd_data | input | DATA_W | Byte written into the holding buffer |
| baud_tick | input | 1 | One-cycle pacing tick for master SCLK edges |
| sdi | input | 1 | Serial data in |
| sclk_in | input | 1 | Serial clock from an external master |
| ss_n_in | input | 1 | Active-low slave select |
| sclk_out | output | 1 | Serial clock driven in master mode |
| sclk_oe | output | 1 | Output enable for sclk_out |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for sdo |
| stat_empty | output | 1 | Holding buffer empty flag |
| stat_busy | output | 1 | Busy flag (meaning depends on mode) |
| irq | output | 1 | Buffer-empty interrupt request |
| rx_byte | output | DATA_W | Last received byte, valid with xfer_done |
| xfer_done | output | 1 | One-cycle strobe at the end of each byte |

## Verification
Two functions can land in the same clock cycle: a write into the holding buffer, and the hand-off of the byte already there into the shift register. This is provoked by two writes on back-to-back cycles while the master is idle, and by refilling the buffer while a byte shifts so that the reload coincides with the final SCLK edge. It is judged at the ports. Both bytes must come out on SDO in write order with no lost byte and no extra SCLK gap, and the buffer-empty flag must read 0 right after the coincident write.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;

    typedef enum logic {
        PH_SAMPLE_LEAD = 1'b0,
        PH_SHIFT_LEAD  = 1'b1
    } spi_phase_e;

    typedef struct packed {
        logic lead;
        logic trail;
    } spi_edge_t;

endpackage

// File: rtl/spi_hold_buf.sv
module spi_hold_buf #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         take,
    output logic [W-1:0] data_o,
    output logic         empty_o
);

    typedef struct packed {
        logic [W-1:0] data;
        logic         empty;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (take) begin
            st_d.empty = 1'b1;
        end
        if (wr_en) begin
            st_d.data  = wr_data;
            st_d.empty = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{data: '0, empty: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign data_o  = st_q.data;
    assign empty_o = st_q.empty;

endmodule

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen
    import spi_xfer_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      run,
    input  logic      cpol,
    input  logic      active,
    input  logic      tick,
    output logic      sclk_o,
    output spi_edge_t edge_o
);

    typedef struct packed {
        logic sclk;
    } gen_t;

    gen_t st_d, st_q;
    logic step;

    always_comb begin
        step         = run && active && tick;
        edge_o.lead  = step && (st_q.sclk == cpol);
        edge_o.trail = step && (st_q.sclk != cpol);
        st_d = st_q;
        if (!run || !active) begin
            st_d.sclk = cpol;
        end else if (tick) begin
            st_d.sclk = ~st_q.sclk;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{sclk: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign sclk_o = st_q.sclk;

endmodule

// File: rtl/spi_slave_sync.sv
module spi_slave_sync
    import spi_xfer_pkg::*;
#(
    parameter int SYNC = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cpol,
    input  logic      sclk_in,
    input  logic      ss_n_in,
    output logic      ss_act_o,
    output spi_edge_t edge_o
);

    localparam int CKW = SYNC + 1;

    typedef struct packed {
        logic [CKW-1:0]  ck;
        logic [SYNC-1:0] ss;
    } sync_t;

    sync_t st_d, st_q;
    logic  chg;
    logic  lvl;

    always_comb begin
        st_d.ck = {st_q.ck[CKW-2:0], sclk_in};
        st_d.ss = {st_q.ss[SYNC-2:0], ss_n_in};
        lvl          = st_q.ck[SYNC-1];
        chg          = st_q.ck[SYNC-1] ^ st_q.ck[SYNC];
        edge_o.lead  = chg && (lvl != cpol);
        edge_o.trail = chg && (lvl == cpol);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ck: '0, ss: '1};
        end else begin
            st_q <= st_d;
        end
    end

    assign ss_act_o = ~st_q.ss[SYNC-1];

endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
    import spi_xfer_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         abort,
    input  logic         cpha,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  spi_edge_t    edges,
    input  logic         sdi,
    output logic         active_o,
    output logic         last_edge_o,
    output logic         sdo_o,
    output logic [W-1:0] rx_o,
    output logic         done_o
);

    localparam int             CW   = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0]  LAST = CW'(W - 1);

    typedef struct packed {
        logic          active;
        logic [W-1:0]  tx;
        logic [W-1:0]  rx;
        logic [CW-1:0] cnt;
        logic          sdo;
        logic          done;
    } core_t;

    core_t      st_d, st_q;
    spi_phase_e ph;

    assign ph          = spi_phase_e'(cpha);
    assign last_edge_o = st_q.active && edges.trail && (st_q.cnt == LAST);

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!run || abort) begin
            st_d.active = 1'b0;
            st_d.cnt    = '0;
        end else begin
            if (st_q.active && edges.lead) begin
                if (ph == PH_SAMPLE_LEAD) begin
                    st_d.rx = {st_q.rx[W-2:0], sdi};
                end else begin
                    st_d.sdo = st_q.tx[W-1];
                    st_d.tx  = {st_q.tx[W-2:0], 1'b0};
                end
            end
            if (st_q.active && edges.trail) begin
                if (ph == PH_SAMPLE_LEAD) begin
                    if (st_q.cnt != LAST) begin
                        st_d.sdo = st_q.tx[W-1];
                        st_d.tx  = {st_q.tx[W-2:0], 1'b0};
                    end
                end else begin
                    st_d.rx = {st_q.rx[W-2:0], sdi};
                end
                if (st_q.cnt == LAST) begin
                    st_d.done   = 1'b1;
                    st_d.active = 1'b0;
                    st_d.cnt    = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            if (load) begin
                st_d.active = 1'b1;
                st_d.cnt    = '0;
                if (ph == PH_SAMPLE_LEAD) begin
                    st_d.sdo = load_data[W-1];
                    st_d.tx  = {load_data[W-2:0], 1'b0};
                end else begin
                    st_d.tx  = load_data;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{active: 1'b0, tx: '0, rx: '0, cnt: '0, sdo: 1'b0, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o = st_q.active;
    assign sdo_o    = st_q.sdo;
    assign rx_o     = st_q.rx;
    assign done_o   = st_q.done;

endmodule

// File: rtl/spi_xfer_ctrl.sv
module spi_xfer_ctrl
    import spi_xfer_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic              cfg_master,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic              cfg_irq_en,
    input  logic              txd_wr,
    input  logic [DATA_W-1:0] txd_data,
    input  logic              baud_tick,
    input  logic              sdi,
    input  logic              sclk_in,
    input  logic              ss_n_in,
    output logic              sclk_out,
    output logic              sclk_oe,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              stat_empty,
    output logic              stat_busy,
    output logic              irq,
    output logic [DATA_W-1:0] rx_byte,
    output logic              xfer_done
);

    logic              master_run;
    logic              slave_sel;
    logic              ss_act;
    logic              core_active;
    logic              core_last;
    logic              load;
    logic              abort;
    logic [DATA_W-1:0] buf_data;
    spi_edge_t         m_edge;
    spi_edge_t         s_edge;
    spi_edge_t         sel_edge;

    always_comb begin
        master_run = cfg_en && cfg_master;
        slave_sel  = cfg_en && !cfg_master && ss_act;
        abort      = cfg_en && !cfg_master && !ss_act;
        load       = (master_run || slave_sel) && !stat_empty
                     && (!core_active || core_last);
        if (cfg_master) begin
            sel_edge = m_edge;
        end else begin
            sel_edge.lead  = s_edge.lead  && slave_sel;
            sel_edge.trail = s_edge.trail && slave_sel;
        end
    end

    spi_hold_buf #(.W(DATA_W)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (txd_wr),
        .wr_data (txd_data),
        .take    (load),
        .data_o  (buf_data),
        .empty_o (stat_empty)
    );

    spi_sclk_gen u_gen (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (master_run),
        .cpol   (cfg_cpol),
        .active (core_active),
        .tick   (baud_tick),
        .sclk_o (sclk_out),
        .edge_o (m_edge)
    );

    spi_slave_sync #(.SYNC(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpol     (cfg_cpol),
        .sclk_in  (sclk_in),
        .ss_n_in  (ss_n_in),
        .ss_act_o (ss_act),
        .edge_o   (s_edge)
    );

    spi_shift_core #(.W(DATA_W)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (cfg_en),
        .abort       (abort),
        .cpha        (cfg_cpha),
        .load        (load),
        .load_data   (buf_data),
        .edges       (sel_edge),
        .sdi         (sdi),
        .active_o    (core_active),
        .last_edge_o (core_last),
        .sdo_o       (sdo),
        .rx_o        (rx_byte),
        .done_o      (xfer_done)
    );

    assign sclk_oe   = master_run;
    assign sdo_oe    = master_run || slave_sel;
    assign stat_busy = cfg_master ? core_active : ss_act;
    assign irq       = stat_empty && cfg_irq_en;

endmodule

// File: rtl/spi_xfer_ctrl_chk.sv
module spi_xfer_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_en,
    input logic cfg_master,
    input logic baud_tick,
    input logic txd_wr,
    input logic stat_empty,
    input logic stat_busy,
    input logic irq,
    input logic sclk_out
);

    AST_WR_FILLS_BUF: assert property (@(posedge clk) disable iff (!rst_n)
        txd_wr |=> !stat_empty); // R3

    AST_EMPTY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_empty) |-> stat_busy); // R3

    AST_OFF_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> (!stat_busy || !cfg_master)); // R2

    AST_BUSY_ENDS_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en && cfg_master && stat_busy && !baud_tick) |=> stat_busy); // R7

    AST_SCLK_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en && cfg_master && !baud_tick) |=> (!cfg_master || $stable(sclk_out))); // R6

    AST_WR_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        txd_wr |=> !irq); // R11

endmodule

bind spi_xfer_ctrl spi_xfer_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_en     (cfg_en),
    .cfg_master (cfg_master),
    .baud_tick  (baud_tick),
    .txd_wr     (txd_wr),
    .stat_empty (stat_empty),
    .stat_busy  (stat_busy),
    .irq        (irq),
    .sclk_out   (sclk_out)
);

// File: tb/spi_xfer_ctrl_bench.sv
`timescale 1ns/1ps
module spi_xfer_ctrl_bench;

    localparam int H = 6;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_en, cfg_master, cfg_cpol, cfg_cpha, cfg_irq_en;
    logic       txd_wr;
    logic [7:0] txd_data;
    logic       baud_tick, sdi, sclk_in, ss_n_in;
    logic       sclk_out, sclk_oe, sdo, sdo_oe, stat_empty, stat_busy, irq;
    logic [7:0] rx_byte;
    logic       xfer_done;
    int         n_tests = 0;
    int         n_fail  = 0;

    always #10 clk = ~clk;

    spi_xfer_ctrl u_spi_xfer_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_master(cfg_master),
        .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_irq_en(cfg_irq_en),
        .txd_wr(txd_wr), .txd_data(txd_data), .baud_tick(baud_tick), .sdi(sdi),
        .sclk_in(sclk_in), .ss_n_in(ss_n_in), .sclk_out(sclk_out), .sclk_oe(sclk_oe),
        .sdo(sdo), .sdo_oe(sdo_oe), .stat_empty(stat_empty), .stat_busy(stat_busy),
        .irq(irq), .rx_byte(rx_byte), .xfer_done(xfer_done)
    );

    function automatic logic bit_of(input logic [7:0] b, input int i);
        return b[7-i];
    endfunction

    function automatic logic lead_level(input logic cpol);
        return ~cpol;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_byte(input logic [7:0] b);
        txd_wr = 1'b1; txd_data = b;
        cyc(1);
        txd_wr = 1'b0;
    endtask

    task automatic set_cfg(input logic m, input logic pol, input logic pha);
        cfg_en = 1'b0; cyc(1);
        cfg_master = m; cfg_cpol = pol; cfg_cpha = pha;
        sclk_in = pol; cyc(4);
        cfg_en = 1'b1; cyc(1);
    endtask

    // bench acting as the slave peer of a master-mode transfer
    task automatic master_run(input int nb, input logic [7:0] t0, t1, r0, r1);
        logic       prev;
        logic [7:0] got;
        prev = sclk_out;
        got  = '0;
        if (!cfg_cpha) sdi = r0[7];
        for (int e = 0; e < 16 * nb; e++) begin
            int         by;
            int         w;
            int         bi;
            bit         ld;
            logic [7:0] tb;
            logic [7:0] rb;
            by = e / 16; w = e % 16; bi = w / 2; ld = (w % 2 == 0);
            tb = (by == 0) ? t0 : t1;
            rb = (by == 0) ? r0 : r1;
            baud_tick = 1'b1; cyc(1); baud_tick = 1'b0;
            check(sclk_out != prev, "R6 toggle per tick", sclk_out, ~prev);
            check(sclk_out == (ld ? lead_level(cfg_cpol) : cfg_cpol), "R6 level", sclk_out, ld);
            prev = sclk_out;
            if (ld != cfg_cpha) got[7-bi] = sdo;
            if (ld == cfg_cpha) begin
                if (cfg_cpha) sdi = bit_of(rb, bi);
                else if (bi < 7) sdi = bit_of(rb, bi + 1);
                else if (by + 1 < nb) sdi = r1[7];
            end
            if (w == 15) begin
                check(xfer_done == 1'b1, "R12 done strobe", xfer_done, 1);
                check(rx_byte == rb, "R12 rx byte", rx_byte, rb);
                check(got == tb, "R5 MSB-first data", got, tb);
                got = '0;
                if (e != 16 * nb - 1) check(stat_busy == 1'b1, "R8 no gap", stat_busy, 1);
                else check(stat_busy == 1'b0, "R7 busy end", stat_busy, 0);
            end else begin
                check(stat_busy == 1'b1, "R7 busy mid", stat_busy, 1);
            end
            cyc(2);
            check(sclk_out == prev, "R6 hold between ticks", sclk_out, prev);
        end
        check(sclk_out == cfg_cpol, "R6 idle level", sclk_out, cfg_cpol);
    endtask

    // bench acting as the master of a slave-mode transfer
    task automatic slave_run(input logic [7:0] t, r, input int nbits);
        logic [7:0] got;
        got = '0;
        for (int i = 0; i < nbits; i++) begin
            if (!cfg_cpha) begin
                got[7-i] = sdo; sdi = bit_of(r, i);
                cyc(H); sclk_in = lead_level(cfg_cpol);
                cyc(H); sclk_in = cfg_cpol;
                cyc(H);
            end else begin
                sclk_in = lead_level(cfg_cpol); sdi = bit_of(r, i);
                cyc(H); got[7-i] = sdo; sclk_in = cfg_cpol;
                cyc(H);
            end
        end
        if (nbits == 8) begin
            check(got == t, "R5 slave data", got, t);
            check(rx_byte == r, "R12 slave rx", rx_byte, r);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] a, b, ra, rb;
        void'($urandom(32'd2024));
        rst_n = 1'b0; cfg_en = 0; cfg_master = 1; cfg_cpol = 0; cfg_cpha = 0;
        cfg_irq_en = 0; txd_wr = 0; txd_data = '0; baud_tick = 0; sdi = 0;
        sclk_in = 0; ss_n_in = 1;
        cyc(3); rst_n = 1'b1; cyc(1);

        check(stat_empty == 1'b1, "R1 empty", stat_empty, 1);
        check(stat_busy == 1'b0, "R1 busy", stat_busy, 0);
        check(sdo == 1'b0, "R1 sdo", sdo, 0);
        check(sclk_oe == 1'b0 && irq == 1'b0, "R1 oe/irq", {sclk_oe, irq}, 0);

        cfg_irq_en = 1'b1; cyc(1);
        check(irq == 1'b1, "R11 irq on empty", irq, 1);
        wr_byte(8'h3C);
        check(stat_empty == 1'b0, "R3 write fills", stat_empty, 0);
        check(irq == 1'b0, "R11 irq off when full", irq, 0);

        for (int k = 0; k < 4; k++) begin
            baud_tick = 1'b1; cyc(1); baud_tick = 1'b0; cyc(1);
        end
        check(sclk_oe == 1'b0 && sclk_out == cfg_cpol, "R2 clock inhibited", {sclk_oe, sclk_out}, 0);
        check(stat_empty == 1'b0 && stat_busy == 1'b0, "R2 no load", {stat_empty, stat_busy}, 0);

        wr_byte(8'hA5);
        check(stat_empty == 1'b0, "R4 still full", stat_empty, 0);
        cfg_en = 1'b1; cyc(2);
        check(stat_empty == 1'b1 && stat_busy == 1'b1, "R7 load sets busy", {stat_empty, stat_busy}, 3);
        check(irq == 1'b1, "R11 irq after load", irq, 1);
        master_run(1, 8'hA5, 8'h00, 8'h5A, 8'h00); // R4: 8'h3C must not appear
        check(stat_empty == 1'b1, "R4 lost byte not queued", stat_empty, 1);

        // coincident write and hand-off
        txd_wr = 1'b1; txd_data = 8'hC3; cyc(1);
        txd_data = 8'h81; cyc(1); txd_wr = 1'b0;
        check(stat_empty == 1'b0, "R3 coincident write kept", stat_empty, 0);
        check(stat_busy == 1'b1, "R3 first byte loaded", stat_busy, 1);
        master_run(2, 8'hC3, 8'h81, 8'h0F, 8'hF0);

        set_cfg(1'b1, 1'b1, 1'b1);
        wr_byte(8'h96); cyc(2); wr_byte(8'h69);
        master_run(2, 8'h96, 8'h69, 8'hE7, 8'h18);

        for (int it = 0; it < 8; it++) begin
            int nb;
            set_cfg(1'b1, 1'($urandom), 1'($urandom));
            nb = 1 + int'($urandom % 2);
            a = 8'($urandom); b = 8'($urandom); ra = 8'($urandom); rb = 8'($urandom);
            wr_byte(a); cyc(2);
            if (nb == 2) wr_byte(b);
            master_run(nb, a, b, ra, rb);
        end

        // slave mode
        set_cfg(1'b0, 1'b0, 1'b0);
        check(sdo_oe == 1'b0 && stat_busy == 1'b0, "R9 deselected idle", {sdo_oe, stat_busy}, 0);
        for (int k = 0; k < 4; k++) begin
            sclk_in = ~sclk_in; cyc(H);
        end
        wr_byte(8'hB4); cyc(3);
        check(stat_empty == 1'b0, "R10 no load while deselected", stat_empty, 0);
        ss_n_in = 1'b0; cyc(4);
        check(stat_busy == 1'b1, "R9 busy follows select", stat_busy, 1);
        check(stat_empty == 1'b1, "R3 slave load", stat_empty, 1);
        slave_run(8'hB4, 8'h2D, 8);
        ss_n_in = 1'b1; cyc(4);
        check(stat_busy == 1'b0, "R9 busy drops", stat_busy, 0);

        // abort mid-byte, holding byte kept
        set_cfg(1'b0, 1'b1, 1'b1);
        wr_byte(8'hF1); ss_n_in = 1'b0; cyc(4);
        wr_byte(8'h4E);
        slave_run(8'hF1, 8'h00, 3);
        ss_n_in = 1'b1; cyc(4);
        check(stat_busy == 1'b0, "R10 abort deselect", stat_busy, 0);
        check(stat_empty == 1'b0, "R10 held byte kept", stat_empty, 0);
        ss_n_in = 1'b0; cyc(4);
        check(stat_empty == 1'b1, "R10 held byte loaded", stat_empty, 1);
        slave_run(8'h4E, 8'h99, 8);
        ss_n_in = 1'b1; cyc(4);

        for (int it = 0; it < 4; it++) begin
            set_cfg(1'b0, 1'($urandom), 1'($urandom));
            a = 8'($urandom); b = 8'($urandom); ra = 8'($urandom); rb = 8'($urandom);
            wr_byte(a); ss_n_in = 1'b0; cyc(4);
            wr_byte(b);
            slave_run(a, ra, 8);
            cyc(1);
            check(stat_empty == 1'b1, "R8 slave reload", stat_empty, 1);
            slave_run(b, rb, 8);
            ss_n_in = 1'b1; cyc(4);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule